// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives fixed-length frames over a clocked synchronous serial link. One data line is sampled on each rising edge of a serial clock. That clock is either taken from an external input pin or generated inside the block, and in the second case it is also driven out so that the sending side can follow it. The bits are gathered least significant bit first in a shift register. That register is kept apart from the holding register that the host reads.

When a frame is complete and the holding register is free, the byte moves into the holding register and a receive-full flag is set. The host reads the byte and pulses a read strobe, which frees the register for the next frame. If a frame completes while the previous byte is still unread, the new frame is dropped and an overrun flag is raised. The overrun flag stays set until the host clears it. One receive-interrupt enable gates both interrupt request outputs: one for received data and one for the error.

Top module: `sync_serial_rx`

## Requirements
- R1: A frame is DATA_W (default 8) bits sent least significant bit first. The first bit sampled lands in `rxData[0]` and the last bit sampled lands in `rxData[DATA_W-1]`.
- R2: A frame that completes while `rxFull` = 0 and `overrun` = 0 is copied into `rxData`, and `rxFull` is set to 1.
- R3: A one-cycle pulse on `rdStrobe` clears `rxFull` to 0. `rxData` keeps its value.
- R4: A frame that completes while `rxFull` = 1 sets `overrun` to 1. In that case `rxData` keeps the earlier byte and `rxFull` stays 1.
- R5: `overrun` stays 1 until a pulse on `ovrClear`. While `overrun` = 1, completed frames are dropped, even when `rxFull` = 0.
- R6: `rxIrq` equals `rxFull` AND `rxIntEn`, and `errIrq` equals `overrun` AND `rxIntEn`. Both are level outputs.
- R7: While `rxEnable` = 0, the bit count and the shift register are held at zero and serial clock edges are ignored. A partial frame is therefore dropped, and the next frame starts on a frame boundary.
- R8: With `clkSelInt` = 1 and `rxEnable` = 1, `serClkOut` toggles every DIV_HALF system clocks and this generated clock samples the data. Otherwise `serClkOut` rests at 1. With `clkSelInt` = 0, `extSerClk` samples the data.
- R9: `serData` is sampled on the rising edge of the selected serial clock. The clock and the data each pass through a two-flop synchronizer, so the data must be stable for at least two system clocks around the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive enable; low holds the frame logic idle |
| clkSelInt | input | 1 | 1 selects the internally generated serial clock, 0 selects the external one |
| extSerClk | input | 1 | External serial clock |
| serData | input | 1 | Serial data line |
| rdStrobe | input | 1 | Host read pulse that clears the receive-full flag |
| ovrClear | input | 1 | Write-one-to-clear pulse for the overrun flag |
| rxIntEn | input | 1 | Receive-interrupt enable |
| serClkOut | output | 1 | Generated serial clock output |
| rxData | output | DATA_W | Received data register |
| rxFull | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun error flag |
| rxIrq | output | 1 | Receive-data interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The hardest state to reach is a frame that completes while `overrun` is already set and `rxFull` has been cleared. Reaching it takes three steps: two frames back to back with no read in between, then a read with no overrun clear, then a third frame. That frame has to vanish without touching `rxData` or `rxFull`. The bench also drops `rxEnable` in the middle of a frame to show that the next byte still arrives intact. It then runs a frame in internal-clock mode, placing each data bit on the falling edge of the generated clock.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  typedef struct packed {
    logic shiftBit;  // shift one synchronized bit into the shift register
    logic loadData;  // copy the completed frame into the data register
    logic clearAll;  // hold the shift register at zero
  } ssrx_strobe_t;
endpackage

// File: rtl/ssrx_datapath.sv
module ssrx_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serData,
  input  ssrx_pkg::ssrx_strobe_t strobe,
  output logic [DATA_W-1:0]     rxData
);
  logic dataMeta, dataSync;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextByte;

  // LSB first: each new bit enters at the top and moves down
  assign nextByte = {dataSync, shiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataMeta <= 1'b0;
      dataSync <= 1'b0;
    end else begin
      dataMeta <= serData;
      dataSync <= dataMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearAll) begin
      shiftReg <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (strobe.loadData) begin
      rxData <= nextByte;
    end
  end
endmodule

// File: rtl/ssrx_control.sv
module ssrx_control #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxEnable,
  input  logic                   clkSelInt,
  input  logic                   extSerClk,
  input  logic                   rdStrobe,
  input  logic                   ovrClear,
  output logic                   serClkOut,
  output logic                   rxFull,
  output logic                   overrun,
  output ssrx_pkg::ssrx_strobe_t strobe
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

  logic genRun;
  logic [DIV_W-1:0] divCnt;
  logic rawClk, clkMeta, clkSync, clkPrev;
  logic riseEdge, frameDone, accept;
  logic [CNT_W-1:0] bitCnt;

  assign genRun = rxEnable && clkSelInt;

  // generated serial clock, resting high while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      serClkOut <= 1'b1;
    end else if (!genRun) begin
      divCnt    <= '0;
      serClkOut <= 1'b1;
    end else if (divCnt == DIV_LAST) begin
      divCnt    <= '0;
      serClkOut <= ~serClkOut;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign rawClk = clkSelInt ? serClkOut : extSerClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkMeta <= 1'b1;
      clkSync <= 1'b1;
      clkPrev <= 1'b1;
    end else begin
      clkMeta <= rawClk;
      clkSync <= clkMeta;
      clkPrev <= clkSync;
    end
  end

  assign riseEdge  = rxEnable && clkSync && !clkPrev;
  assign frameDone = riseEdge && (bitCnt == LAST_BIT);
  assign accept    = frameDone && !rxFull && !overrun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!rxEnable || frameDone) begin
      bitCnt <= '0;
    end else if (riseEdge) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
    end else if (accept) begin
      rxFull <= 1'b1;
    end else if (rdStrobe) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (frameDone && rxFull) begin
      overrun <= 1'b1;
    end else if (ovrClear) begin
      overrun <= 1'b0;
    end
  end

  always_comb begin
    strobe.shiftBit = riseEdge;
    strobe.loadData = accept;
    strobe.clearAll = !rxEnable;
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              clkSelInt,
  input  logic              extSerClk,
  input  logic              serData,
  input  logic              rdStrobe,
  input  logic              ovrClear,
  input  logic              rxIntEn,
  output logic              serClkOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              overrun,
  output logic              rxIrq,
  output logic              errIrq
);
  ssrx_pkg::ssrx_strobe_t strobe;

  ssrx_control #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clkSelInt(clkSelInt),
    .extSerClk(extSerClk), .rdStrobe(rdStrobe), .ovrClear(ovrClear),
    .serClkOut(serClkOut), .rxFull(rxFull), .overrun(overrun), .strobe(strobe)
  );

  ssrx_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .serData(serData), .strobe(strobe), .rxData(rxData)
  );

  assign rxIrq  = rxFull && rxIntEn;
  assign errIrq = overrun && rxIntEn;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              ovrClear,
  input logic              rxIntEn,
  input logic              serClkOut,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              overrun,
  input logic              rxIrq,
  input logic              errIrq
);
  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $rose(rxFull)); // R2
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData) && $past(rxFull)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClear |=> overrun); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> !rxIrq && !errIrq); // R6
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> serClkOut); // R8
endmodule

bind sync_serial_rx ssrx_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .ovrClear(ovrClear),
  .rxIntEn(rxIntEn), .serClkOut(serClkOut), .rxData(rxData), .rxFull(rxFull),
  .overrun(overrun), .rxIrq(rxIrq), .errIrq(errIrq)
);

// File: tb/sync_serial_rx_test.sv
`timescale 1ns/1ps
module sync_serial_rx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, clkSelInt = 1'b0, extSerClk = 1'b1, serData = 1'b0;
  logic rdStrobe = 1'b0, ovrClear = 1'b0, rxIntEn = 1'b1;
  logic serClkOut, rxFull, overrun, rxIrq, errIrq;
  logic [7:0] rxData;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_serial_rx #(.DATA_W(8), .DIV_HALF(4)) uut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clkSelInt(clkSelInt),
    .extSerClk(extSerClk), .serData(serData), .rdStrobe(rdStrobe),
    .ovrClear(ovrClear), .rxIntEn(rxIntEn), .serClkOut(serClkOut),
    .rxData(rxData), .rxFull(rxFull), .overrun(overrun), .rxIrq(rxIrq),
    .errIrq(errIrq)
  );

  localparam logic [7:0] VEC [8] = '{8'hA5, 8'h01, 8'h80, 8'hFF,
                                     8'h00, 8'h3C, 8'h96, 8'h5A};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // external clock: data set while clock low, sampled on rise
  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      serData = b[i];
      extSerClk = 1'b0;
      waitClk(4);
      extSerClk = 1'b1;
      waitClk(4);
    end
    waitClk(2);
  endtask

  task automatic pulseRead();
    rdStrobe = 1'b1; waitClk(1); rdStrobe = 1'b0; waitClk(1);
  endtask

  task automatic pulseOvrClear();
    ovrClear = 1'b1; waitClk(1); ovrClear = 1'b0; waitClk(1);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    check("R2 reset rxFull", rxFull, 0);
    check("R5 reset overrun", overrun, 0);
    check("R8 reset serClkOut", serClkOut, 1);
    rxEnable = 1'b1;
    waitClk(2);

    // vector table: R1 ordering, R2 load, R3 read clear, R6 irq
    for (int v = 0; v < 8; v++) begin
      sendBits(VEC[v], 8);
      check("R1 rxData", rxData, VEC[v]);
      check("R2 rxFull set", rxFull, 1);
      check("R6 rxIrq", rxIrq, 1);
      pulseRead();
      check("R3 rxFull cleared", rxFull, 0);
      check("R3 rxData kept", rxData, VEC[v]);
    end

    // R4 overrun
    sendBits(8'h11, 8);
    sendBits(8'h22, 8);
    check("R4 overrun set", overrun, 1);
    check("R4 rxData kept", rxData, 8'h11);
    check("R4 rxFull kept", rxFull, 1);
    check("R6 errIrq", errIrq, 1);
    // R5: read but keep overrun, next frame is dropped
    pulseRead();
    sendBits(8'h33, 8);
    check("R5 frame dropped rxFull", rxFull, 0);
    check("R5 frame dropped rxData", rxData, 8'h11);
    check("R5 overrun sticky", overrun, 1);
    pulseOvrClear();
    check("R5 overrun cleared", overrun, 0);
    sendBits(8'h44, 8);
    check("R5 receive after clear", rxData, 8'h44);

    // R6 masking
    rxIntEn = 1'b0;
    waitClk(1);
    check("R6 rxIrq masked", rxIrq, 0);
    check("R6 rxFull still set", rxFull, 1);
    rxIntEn = 1'b1;
    pulseRead();

    // R7 partial frame discarded by disable
    sendBits(8'hFF, 4);
    rxEnable = 1'b0; waitClk(3);
    rxEnable = 1'b1; waitClk(2);
    check("R7 partial not loaded", rxFull, 0);
    sendBits(8'hC3, 8);
    check("R7 frame realigned", rxData, 8'hC3);
    check("R7 rxFull", rxFull, 1);
    pulseRead();

    // R8 / R9 internal clock
    rxEnable = 1'b0; waitClk(2);
    clkSelInt = 1'b1; rxEnable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge serClkOut);
      serData = (8'h6D >> i) & 1;
      @(posedge serClkOut);
    end
    @(negedge serClkOut);
    rxEnable = 1'b0;
    waitClk(3);
    check("R8 internal clock frame", rxData, 8'h6D);
    check("R9 rxFull internal", rxFull, 1);
    check("R8 serClkOut idle", serClkOut, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule